// File: doc/BRIEF.md
# Mode-Dependent Five-Pin Multiplexed I/O Port

This block is a five-pin bidirectional port that sits on a simple byte-wide register bus. It holds two registers: a direction register, which can be written but never read back, and a data register, which can be both written and read. Each pin has its own output value, output enable and input level. The two registers and a small amount of pin muxing decide which source drives each pin.

An operating-mode input is captured while reset is held. In the expanded modes (1 to 6), the upper four pins carry externally generated chip-select lines whenever their direction bit is set. The lowest pin is taken over by an external refresh strobe while refresh is enabled. In single-chip mode (7, and also 0), every pin is plain general-purpose I/O, driven from the data register. The reset value of the direction register depends on the captured mode. Reads of the data register mix register bits with synchronized pin levels.

Top module: `xport_mux`

## Requirements
- R1: Reset is synchronous and active low, and the mode input is captured while reset is low. In captured modes 1 to 4, the direction register resets to 5'b10000. In all other modes it resets to 5'b00000. The data register resets to 5'b00000 in every mode.
- R2: A read at the direction address (default 0xFFCD) returns 0xFF, whatever value was written there.
- R3: A read at the data address (default 0xFFCF) returns 3'b111 in bits 7:5. Each bit i of bits 4:0 returns the data-register bit when pin i is a general-purpose output. Otherwise it returns pin_in[i] as seen through a two-stage synchronizer.
- R4: In expanded modes 1 to 6, pins 4, 3, 2 and 1 are enabled exactly when their direction bit is 1. When enabled, they drive chip_sel[0], chip_sel[1], chip_sel[2] and chip_sel[3] respectively.
- R5: In expanded modes with rfsh_en high, pin 0 is always enabled and drives rfsh_strobe, whatever its direction bit holds.
- R6: In expanded modes with rfsh_en low, pin 0 is a general-purpose pin. It is enabled by direction bit 0 and driven by data bit 0.
- R7: In mode 7, and in mode 0, which is treated as mode 7, every pin i is enabled by direction bit i and driven by data bit i. In this mode chip_sel, rfsh_strobe and rfsh_en have no effect.
- R8: Changes on mode_i while reset is high have no effect on pin behaviour.
- R9: Writes update only bits 4:0 of the addressed register. Writes to any other address leave both registers unchanged.
- R10: bus_rdata is 0x00 when bus_rd is low or when the address matches neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 3 | Operating mode, captured during reset |
| bus_addr | input | ADDR_W | Register bus address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| chip_sel | input | 4 | Chip-select lines 0..3 from the external generator |
| rfsh_strobe | input | 1 | Refresh strobe from the external generator |
| rfsh_en | input | 1 | Refresh controller enabled |
| pin_in | input | 5 | Pin input levels |
| pin_out | output | 5 | Pin output values |
| pin_oe | output | 5 | Pin output enables |

## Verification
Every captured mode from 0 to 7 is tested. In each mode, all 32 direction values are swept, each with refresh enabled and with refresh disabled. Every pin enable and every enabled output is compared against a value the bench computes arithmetically.

The data value, the chip-select pattern and the pin levels are derived so that they differ from one another. This lets a mismatch show which source drove a pin or a readback bit: the data register, a chip-select line, the refresh strobe or the synchronized input. Modes 1 to 4 and 5 to 6 are both included, which separates the two reset values of the direction register. After reset, mode_i is deliberately changed, so any pin behaviour that follows the live input instead of the captured mode shows up. Writes and reads at neighbouring addresses check that decoding is exact.

// File: rtl/xport_mux.sv
module xport_mux #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] DIR_ADDR = 'hFFCD,
  parameter logic [ADDR_W-1:0] DAT_ADDR = 'hFFCF,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode_i,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [3:0]        chip_sel,
  input  logic              rfsh_strobe,
  input  logic              rfsh_en,
  input  logic [4:0]        pin_in,
  output logic [4:0]        pin_out,
  output logic [4:0]        pin_oe
);

  localparam logic [2:0] RSV_BITS = 3'b111;
  localparam logic [4:0] CS0_RESET = 5'b10000;

  logic [2:0] mode_q;
  logic [4:0] dir_q, dat_q;
  logic [4:0] sync_q [SYNC_STAGES];
  logic       expanded, rom_off, rfsh_own, sel_dir, sel_dat;
  logic [4:0] cs_map, gpio_oe, rd_bits;

  assign rom_off  = (mode_i >= 3'd1) && (mode_i <= 3'd4);
  assign expanded = (mode_q != 3'd0) && (mode_q != 3'd7);
  assign rfsh_own = expanded & rfsh_en;
  assign sel_dir  = (bus_addr == DIR_ADDR);
  assign sel_dat  = (bus_addr == DAT_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= mode_i;
      dir_q  <= rom_off ? CS0_RESET : 5'b00000;
      dat_q  <= 5'b00000;
    end else begin
      if (bus_wr && sel_dir) dir_q <= bus_wdata[4:0];
      if (bus_wr && sel_dat) dat_q <= bus_wdata[4:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SYNC_STAGES; s++) sync_q[s] <= '0;
    end else begin
      sync_q[0] <= pin_in;
      for (int s = 1; s < SYNC_STAGES; s++) sync_q[s] <= sync_q[s-1];
    end
  end

  assign cs_map  = {chip_sel[0], chip_sel[1], chip_sel[2], chip_sel[3], 1'b0};
  assign gpio_oe = expanded ? {4'b0000, dir_q[0] & ~rfsh_own} : dir_q;
  assign pin_oe  = expanded ? {dir_q[4:1], dir_q[0] | rfsh_own} : dir_q;
  assign pin_out = expanded ? {cs_map[4:1], rfsh_own ? rfsh_strobe : dat_q[0]} : dat_q;
  assign rd_bits = (gpio_oe & dat_q) | (~gpio_oe & sync_q[SYNC_STAGES-1]);

  assign bus_rdata = !bus_rd ? 8'h00 :
                     sel_dir ? 8'hFF :
                     sel_dat ? {RSV_BITS, rd_bits} : 8'h00;

endmodule

// File: rtl/xport_mux_chk.sv
module xport_mux_chk #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] DIR_ADDR = 'hFFCD,
  parameter logic [ADDR_W-1:0] DAT_ADDR = 'hFFCF
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        mode_q,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [7:0]        bus_rdata,
  input logic [3:0]        chip_sel,
  input logic              rfsh_strobe,
  input logic              rfsh_en,
  input logic [4:0]        pin_out,
  input logic [4:0]        pin_oe,
  input logic [4:0]        dir_q,
  input logic [4:0]        dat_q
);

  logic       ex;
  logic [4:0] cs_exp;
  assign ex     = (mode_q != 3'd0) && (mode_q != 3'd7);
  assign cs_exp = {chip_sel[0], chip_sel[1], chip_sel[2], chip_sel[3], 1'b0};

  assert_dir_reads_ones_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == DIR_ADDR) |-> bus_rdata == 8'hFF);

  assert_reserved_ones_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == DAT_ADDR) |-> bus_rdata[7:5] == 3'b111);

  assert_cs_routing_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ex |-> ((pin_out[4:1] ^ cs_exp[4:1]) & pin_oe[4:1]) == 4'b0000);

  assert_refresh_owns_pin0_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ex && rfsh_en) |-> (pin_oe[0] && pin_out[0] == rfsh_strobe));

  assert_single_chip_gpio_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ex |-> (((pin_out ^ dat_q) & pin_oe) == 5'b00000 && pin_oe == dir_q));

  assert_mode_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $stable(mode_q));

  assert_foreign_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr != DIR_ADDR && bus_addr != DAT_ADDR) |=> ($stable(dir_q) && $stable(dat_q)));

  assert_idle_read_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> bus_rdata == 8'h00);

endmodule

bind xport_mux xport_mux_chk #(.ADDR_W(ADDR_W), .DIR_ADDR(DIR_ADDR), .DAT_ADDR(DAT_ADDR)) u_chk (.*);

// File: tb/tb_xport_mux.sv
`timescale 1ns/1ps
module tb_xport_mux;
  localparam logic [15:0] A_DIR = 16'hFFCD;
  localparam logic [15:0] A_DAT = 16'hFFCF;

  logic clk = 0, rst_n = 0;
  logic [2:0] mode_i = 0;
  logic [15:0] bus_addr = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic [3:0] chip_sel = 0;
  logic rfsh_strobe = 0, rfsh_en = 0;
  logic [4:0] pin_in = 0, pin_out, pin_oe;

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  xport_mux dut (.*);

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit is_ex(int m);
    return m >= 1 && m <= 6;
  endfunction

  function automatic logic [4:0] e_oe(int m, logic [4:0] d, logic rf);
    return is_ex(m) ? {d[4:1], d[0] | rf} : d;
  endfunction

  function automatic logic [4:0] e_out(int m, logic [4:0] dt, logic [3:0] cs, logic rs, logic rf);
    return is_ex(m) ? {cs[0], cs[1], cs[2], cs[3], rf ? rs : dt[0]} : dt;
  endfunction

  function automatic logic [4:0] e_gpio(int m, logic [4:0] d, logic rf);
    return is_ex(m) ? {4'b0000, d[0] & ~rf} : d;
  endfunction

  task automatic wr(logic [15:0] a, logic [7:0] v);
    @(negedge clk);
    bus_addr = a; bus_wdata = v; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(logic [15:0] a, output logic [7:0] v);
    bus_addr = a; bus_rd = 1;
    #1 v = bus_rdata;
    bus_rd = 0;
  endtask

  task automatic do_reset(int m);
    @(negedge clk);
    rst_n = 0; mode_i = 3'(m);
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    for (int m = 0; m < 8; m++) begin
      rfsh_en = 0; pin_in = 0;
      do_reset(m);
      #1;
      check("R1 reset oe", {3'b0, pin_oe}, {3'b0, (m >= 1 && m <= 4) ? 5'b10000 : 5'b00000});
      rd(A_DAT, v);
      check("R1 R3 reset data read", v, 8'hE0);
      rd(A_DIR, v);
      check("R2 dir read", v, 8'hFF);
      mode_i = 3'((m + 3) % 8); // R8: live mode changes must be ignored
      for (int d = 0; d < 32; d++) begin
        logic [4:0] dd, dt;
        dd = 5'(d);
        dt = dd ^ 5'h15;
        wr(A_DIR, {3'(d), dd});
        wr(A_DAT, {3'b010, dt});
        for (int rf = 0; rf < 2; rf++) begin
          logic [4:0] eo, eout, gm;
          logic [3:0] cs;
          cs = dd[3:0] ^ 4'hA;
          chip_sel = cs; rfsh_en = rf[0]; rfsh_strobe = ~dd[0]; pin_in = ~dt;
          @(negedge clk); @(negedge clk); @(negedge clk);
          #1;
          eo   = e_oe(m, dd, rf[0]);
          eout = e_out(m, dt, cs, ~dd[0], rf[0]);
          gm   = e_gpio(m, dd, rf[0]);
          check(is_ex(m) ? (rf ? "R4 R5 R8 oe" : "R4 R6 R8 oe") : "R7 R8 oe", {3'b0, pin_oe}, {3'b0, eo});
          check(is_ex(m) ? (rf ? "R4 R5 out" : "R4 R6 out") : "R7 out",
                {3'b0, pin_out & eo}, {3'b0, eout & eo});
          rd(A_DAT, v);
          check("R3 R9 data read", v, {3'b111, (gm & dt) | (~gm & ~dt)});
          rd(A_DIR, v);
          check("R2 dir read", v, 8'hFF);
        end
      end
      // R9: foreign addresses leave registers alone
      wr(A_DIR, 8'h0A);
      wr(A_DAT, 8'h05);
      wr(A_DIR + 16'd1, 8'h15);
      wr(A_DAT + 16'd1, 8'h1A);
      wr(A_DIR - 16'd1, 8'h1F);
      rfsh_en = 0;
      #1;
      check("R9 oe unchanged", {3'b0, pin_oe}, {3'b0, e_oe(m, 5'h0A, 1'b0)});
      pin_in = 5'h00;
      @(negedge clk); @(negedge clk); @(negedge clk);
      rd(A_DAT, v);
      check("R9 data unchanged", v, {3'b111, e_gpio(m, 5'h0A, 1'b0) & 5'h05});
      rd(A_DIR + 16'd1, v);
      check("R10 foreign read", v, 8'h00);
      bus_addr = A_DAT; bus_rd = 0;
      #1 check("R10 idle read", bus_rdata, 8'h00);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule